// File: doc/BRIEF.md
# MESI Line State Controller with Snoop and Flush

This block keeps the coherence state of each line of a small write-back data cache in the four MESI states: Invalid, Shared, Exclusive and Modified. Each line holds one full-address tag. The processor side names a line by a set number and presents an address with one of four operations: read, write, fill and locked read. The block answers with a hit pulse, a write-through pulse or an external-read pulse. A write-back policy input decides two things: whether a fill is installed Exclusive or Shared, and whether a write to a Shared line promotes it.

External logic starts a snoop by strobing an address together with an invalidate flag. The address is compared against every valid line. The block reports a hit, and a separate hit-to-modified indication when the matching line is dirty. A dirty snoop hit first drives a write-back request to the memory port and waits for its acknowledge. Only then does the line leave Modified.

A flush command walks the lines one per cycle. Each dirty line is written back before it is invalidated, and a done pulse marks the end of the walk. Two configuration inputs gate the whole cache. Caching is on only while both inputs are low.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. All pulse outputs, `busy` and `wb_req` are low.
- R2: A fill (`cpu_op`=2) installs `cpu_addr` as the tag of line `cpu_set`. The line is installed Exclusive when `pol_wb` is 1 and Shared when it is 0.
- R3: A read (`cpu_op`=0) that hits a valid line with an equal tag pulses `cpu_hit` for one cycle. A read that misses pulses `ext_rd` instead.
- R4: A write (`cpu_op`=1) to an Exclusive or Modified line leaves it Modified and produces no bus pulse. Any other write pulses `wt_req`. A write that hits a Shared line while `pol_wb` is 1 makes the line Exclusive.
- R5: While `cfg_nocache` or `cfg_nowrite` is 1, every processor lookup misses and fills leave the array unchanged.
- R6: A snoop strobe pulses `snp_hit` in the next cycle exactly when `snp_addr` equals the tag of some valid line. The lowest-numbered matching line is the one acted on.
- R7: A snoop hit on a Modified line also pulses `snp_hitm`. It raises `wb_req` with `wb_addr` equal to the line tag, and both hold until `wb_ack`; the line stays Modified until then.
- R8: On a snoop hit, `snp_inv`=1 makes the line Invalid and `snp_inv`=0 makes it Shared.
- R9: A locked read (`cpu_op`=3) that hits invalidates the line and pulses `ext_rd`. If the line was Modified, the write-back completes first and `ext_rd` pulses in the cycle after `wb_ack`. A locked read that misses pulses `ext_rd`.
- R10: A flush takes line 0 upward, one line per cycle. Each Modified line is written back and acknowledged, and every line becomes Invalid. `flush_done` pulses once after the last line.
- R11: `busy` is high whenever a flush or write-back is in progress, and requests arriving then are ignored. In the same idle cycle a snoop takes priority over a flush, and a flush over a processor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nocache | input | 1 | Cache disable control |
| cfg_nowrite | input | 1 | No-write control |
| cpu_req | input | 1 | Processor request valid |
| cpu_op | input | 2 | 0 read, 1 write, 2 fill, 3 locked read |
| cpu_set | input | IW | Line number addressed |
| cpu_addr | input | AW | Processor address / tag |
| pol_wb | input | 1 | Write-back (1) or write-through (0) policy |
| cpu_hit | output | 1 | Read hit pulse |
| wt_req | output | 1 | Write-through pulse |
| ext_rd | output | 1 | External memory read pulse |
| snp_stb | input | 1 | Snoop address strobe |
| snp_addr | input | AW | Snoop address |
| snp_inv | input | 1 | Invalidate on snoop hit |
| snp_hit | output | 1 | Snoop hit pulse |
| snp_hitm | output | 1 | Snoop hit-to-modified pulse |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | AW | Write-back address |
| wb_ack | input | 1 | Write-back acknowledge |
| flush_req | input | 1 | Flush command |
| flush_done | output | 1 | Flush completion pulse |
| busy | output | 1 | Flush or write-back in progress |

## Verification
Every pulse output (`cpu_hit`, `wt_req`, `ext_rd`, `snp_hit`, `snp_hitm`, `flush_done`) is registered. Each one is due exactly one cycle after the edge that samples its cause. For a locked read on a dirty line, that cause is the acknowledge edge. `busy`, `wb_req` and `wb_addr` follow the state register with no extra delay. The bench runs its model at the same rising edge as the design and compares all outputs on every falling edge. Every expected value is therefore aligned to the cycle in which the design's registers make it visible. The acknowledge is driven from the model's view of the request, two cycles after the request rises.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int LINES = 4,
  parameter int AW    = 32,
  localparam int IW   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_nocache,
  input  logic          cfg_nowrite,
  input  logic          cpu_req,
  input  logic [1:0]    cpu_op,
  input  logic [IW-1:0] cpu_set,
  input  logic [AW-1:0] cpu_addr,
  input  logic          pol_wb,
  output logic          cpu_hit,
  output logic          wt_req,
  output logic          ext_rd,
  input  logic          snp_stb,
  input  logic [AW-1:0] snp_addr,
  input  logic          snp_inv,
  output logic          snp_hit,
  output logic          snp_hitm,
  output logic          wb_req,
  output logic [AW-1:0] wb_addr,
  input  logic          wb_ack,
  input  logic          flush_req,
  output logic          flush_done,
  output logic          busy
);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_FILL = 2'd2, OP_LOCK = 2'd3;

  typedef enum logic [1:0] {F_IDLE, F_SCAN, F_WB} fsm_t;

  logic [1:0]    st  [LINES];
  logic [AW-1:0] tag [LINES];
  fsm_t          fsm;
  logic [IW-1:0] ptr;
  logic [1:0]    wb_final;
  logic          wb_lock, wb_flush;

  wire cache_on = !cfg_nocache && !cfg_nowrite;
  wire [1:0] cst = st[cpu_set];
  wire chit = cache_on && (cst != ST_I) && (tag[cpu_set] == cpu_addr);
  wire idle = (fsm == F_IDLE);
  wire take_snp = idle && snp_stb;
  wire take_fl  = idle && !snp_stb && flush_req;
  wire take_cpu = idle && !snp_stb && !flush_req && cpu_req;
  wire last = (ptr == IW'(LINES - 1));

  logic          s_any;
  logic [IW-1:0] s_idx;
  always_comb begin
    s_any = 1'b0;
    s_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (st[i] != ST_I && tag[i] == snp_addr) begin
        s_any = 1'b1;
        s_idx = IW'(i);
      end
    end
  end

  assign busy    = !idle;
  assign wb_req  = (fsm == F_WB);
  assign wb_addr = tag[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i]  <= ST_I;
        tag[i] <= '0;
      end
      fsm        <= F_IDLE;
      ptr        <= '0;
      wb_final   <= ST_I;
      wb_lock    <= 1'b0;
      wb_flush   <= 1'b0;
      cpu_hit    <= 1'b0;
      wt_req     <= 1'b0;
      ext_rd     <= 1'b0;
      snp_hit    <= 1'b0;
      snp_hitm   <= 1'b0;
      flush_done <= 1'b0;
    end else begin
      cpu_hit    <= 1'b0;
      wt_req     <= 1'b0;
      ext_rd     <= 1'b0;
      snp_hit    <= 1'b0;
      snp_hitm   <= 1'b0;
      flush_done <= 1'b0;
      case (fsm)
        F_IDLE: begin
          if (take_snp) begin
            snp_hit  <= s_any;
            snp_hitm <= s_any && (st[s_idx] == ST_M);
            if (s_any) begin
              if (st[s_idx] == ST_M) begin
                fsm      <= F_WB;
                ptr      <= s_idx;
                wb_final <= snp_inv ? ST_I : ST_S;
                wb_lock  <= 1'b0;
                wb_flush <= 1'b0;
              end else begin
                st[s_idx] <= snp_inv ? ST_I : ST_S;
              end
            end
          end else if (take_fl) begin
            fsm <= F_SCAN;
            ptr <= '0;
          end else if (take_cpu) begin
            case (cpu_op)
              OP_RD: begin
                cpu_hit <= chit;
                ext_rd  <= !chit;
              end
              OP_WR: begin
                wt_req <= !(chit && (cst == ST_E || cst == ST_M));
                if (chit && cst == ST_E) st[cpu_set] <= ST_M;
                else if (chit && cst == ST_S && pol_wb) st[cpu_set] <= ST_E;
              end
              OP_FILL: begin
                if (cache_on) begin
                  st[cpu_set]  <= pol_wb ? ST_E : ST_S;
                  tag[cpu_set] <= cpu_addr;
                end
              end
              default: begin
                if (chit && cst == ST_M) begin
                  fsm      <= F_WB;
                  ptr      <= cpu_set;
                  wb_final <= ST_I;
                  wb_lock  <= 1'b1;
                  wb_flush <= 1'b0;
                end else begin
                  ext_rd <= 1'b1;
                  if (chit) st[cpu_set] <= ST_I;
                end
              end
            endcase
          end
        end
        F_SCAN: begin
          if (st[ptr] == ST_M) begin
            fsm      <= F_WB;
            wb_final <= ST_I;
            wb_lock  <= 1'b0;
            wb_flush <= 1'b1;
          end else begin
            st[ptr] <= ST_I;
            if (last) begin
              fsm        <= F_IDLE;
              flush_done <= 1'b1;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
        end
        default: begin
          if (wb_ack) begin
            st[ptr] <= wb_final;
            ext_rd  <= wb_lock;
            if (wb_flush) begin
              if (last) begin
                fsm        <= F_IDLE;
                flush_done <= 1'b1;
              end else begin
                fsm <= F_SCAN;
                ptr <= ptr + 1'b1;
              end
            end else begin
              fsm <= F_IDLE;
            end
          end
        end
      endcase
    end
  end

  assert_hitm_with_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hitm |-> (snp_hit && wb_req));
  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));
  assert_cpu_hit_no_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> !ext_rd);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !busy);
  assert_busy_blocks_wt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !wt_req);
endmodule

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_nocache = 1'b0, cfg_nowrite = 1'b0;
  logic cpu_req = 1'b0;
  logic [1:0] cpu_op = 2'd0;
  logic [1:0] cpu_set = 2'd0;
  logic [31:0] cpu_addr = '0;
  logic pol_wb = 1'b0;
  logic snp_stb = 1'b0, snp_inv = 1'b0;
  logic [31:0] snp_addr = '0;
  logic wb_ack = 1'b0;
  logic flush_req = 1'b0;
  logic cpu_hit, wt_req, ext_rd, snp_hit, snp_hitm, wb_req, flush_done, busy;
  logic [31:0] wb_addr;

  always #10 clk = ~clk;

  mesi_line_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_nocache(cfg_nocache), .cfg_nowrite(cfg_nowrite),
    .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_set(cpu_set), .cpu_addr(cpu_addr),
    .pol_wb(pol_wb), .cpu_hit(cpu_hit), .wt_req(wt_req), .ext_rd(ext_rd),
    .snp_stb(snp_stb), .snp_addr(snp_addr), .snp_inv(snp_inv), .snp_hit(snp_hit),
    .snp_hitm(snp_hitm), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
    .flush_req(flush_req), .flush_done(flush_done), .busy(busy)
  );

  int checks = 0, fails = 0;
  string phase = "R1";
  bit over = 0;

  // reference model: line states 0=I 1=S 2=E 3=M; mode 0 idle, 1 flush walk, 2 write-back wait
  int mst [4];
  logic [31:0] mtag [4];
  int mmode = 0, mptr = 0, mfin = 0;
  bit mlock = 0, mfl = 0;
  bit e_hit = 0, e_hitm = 0, e_cpu = 0, e_wt = 0, e_ext = 0, e_done = 0;
  int ackcnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin mst[i] = 0; mtag[i] = '0; end
      mmode = 0; mptr = 0;
      e_hit = 0; e_hitm = 0; e_cpu = 0; e_wt = 0; e_ext = 0; e_done = 0;
    end else begin
      bit on, h;
      int s, found;
      e_hit = 0; e_hitm = 0; e_cpu = 0; e_wt = 0; e_ext = 0; e_done = 0;
      on = !cfg_nocache && !cfg_nowrite;
      if (mmode == 0) begin
        if (snp_stb) begin
          found = -1;
          for (int i = 0; i < 4; i++)
            if (found < 0 && mst[i] != 0 && mtag[i] == snp_addr) found = i;
          if (found >= 0) begin
            e_hit = 1;
            if (mst[found] == 3) begin
              e_hitm = 1; mmode = 2; mptr = found; mfin = snp_inv ? 0 : 1; mlock = 0; mfl = 0;
            end else mst[found] = snp_inv ? 0 : 1;
          end
        end else if (flush_req) begin
          mmode = 1; mptr = 0;
        end else if (cpu_req) begin
          s = mst[cpu_set];
          h = on && s != 0 && mtag[cpu_set] == cpu_addr;
          case (cpu_op)
            2'd0: if (h) e_cpu = 1; else e_ext = 1;
            2'd1: begin
              if (h && s >= 2) mst[cpu_set] = 3;
              else begin
                e_wt = 1;
                if (h && pol_wb) mst[cpu_set] = 2;
              end
            end
            2'd2: if (on) begin mst[cpu_set] = pol_wb ? 2 : 1; mtag[cpu_set] = cpu_addr; end
            default: begin
              if (h && s == 3) begin
                mmode = 2; mptr = cpu_set; mfin = 0; mlock = 1; mfl = 0;
              end else begin
                e_ext = 1;
                if (h) mst[cpu_set] = 0;
              end
            end
          endcase
        end
      end else if (mmode == 1) begin
        if (mst[mptr] == 3) begin
          mmode = 2; mfin = 0; mlock = 0; mfl = 1;
        end else begin
          mst[mptr] = 0;
          if (mptr == 3) begin mmode = 0; e_done = 1; end
          else mptr++;
        end
      end else if (wb_ack) begin
        mst[mptr] = mfin;
        if (mlock) e_ext = 1;
        if (mfl) begin
          if (mptr == 3) begin mmode = 0; e_done = 1; end
          else begin mptr++; mmode = 1; end
        end else mmode = 0;
      end
    end
  end

  wire e_busy = (mmode != 0);
  wire e_wbreq = (mmode == 2);
  wire [31:0] e_wbaddr = mtag[mptr];

  task automatic chk(input string tg, input string nm, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tg, nm, a, e);
    end
  endtask

  always @(negedge clk) begin
    if (!over) begin
      chk(phase, "busy", {31'd0, busy}, {31'd0, e_busy});
      chk(phase, "wb_req", {31'd0, wb_req}, {31'd0, e_wbreq});
      if (e_wbreq) chk(phase, "wb_addr", wb_addr, e_wbaddr);
      chk(phase, "cpu_hit", {31'd0, cpu_hit}, {31'd0, e_cpu});
      chk(phase, "wt_req", {31'd0, wt_req}, {31'd0, e_wt});
      chk(phase, "ext_rd", {31'd0, ext_rd}, {31'd0, e_ext});
      chk(phase, "snp_hit", {31'd0, snp_hit}, {31'd0, e_hit});
      chk(phase, "snp_hitm", {31'd0, snp_hitm}, {31'd0, e_hitm});
      chk(phase, "flush_done", {31'd0, flush_done}, {31'd0, e_done});
    end
    wb_ack <= e_wbreq && ackcnt >= 2;
    ackcnt = e_wbreq ? ackcnt + 1 : 0;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu(input logic [1:0] op, input logic [1:0] set, input logic [31:0] a, input logic pol);
    cpu_req = 1; cpu_op = op; cpu_set = set; cpu_addr = a; pol_wb = pol;
    @(negedge clk);
    cpu_req = 0;
    cyc(1);
  endtask

  task automatic snoop(input logic [31:0] a, input logic inv);
    snp_stb = 1; snp_addr = a; snp_inv = inv;
    @(negedge clk);
    snp_stb = 0;
    cyc(1);
    while (e_busy) @(negedge clk);
    cyc(1);
  endtask

  task automatic wait_idle();
    while (e_busy) @(negedge clk);
    cyc(1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 act=running exp=finished");
    over = 1;
    summary();
    $finish;
  end

  initial begin
    phase = "R1";
    cyc(3);
    rst_n = 1;
    cyc(2);

    phase = "R2";
    cpu(2, 0, 32'h100, 1);
    cpu(2, 1, 32'h200, 0);
    phase = "R3";
    cpu(0, 0, 32'h100, 0);
    cpu(0, 2, 32'h300, 0);
    cpu(0, 0, 32'h108, 0);

    phase = "R4";
    cpu(1, 0, 32'h100, 0);
    cpu(1, 1, 32'h200, 0);
    cpu(1, 1, 32'h200, 1);
    cpu(1, 1, 32'h200, 0);
    cpu(1, 3, 32'h400, 1);

    phase = "R7";
    snoop(32'h200, 0);
    phase = "R8";
    snoop(32'h200, 1);
    snoop(32'h200, 0);
    phase = "R7";
    snoop(32'h100, 0);
    phase = "R6";
    snoop(32'h999, 1);
    cpu(2, 2, 32'h300, 1);
    phase = "R8";
    snoop(32'h300, 0);
    cpu(1, 2, 32'h300, 0);

    phase = "R9";
    cpu(2, 3, 32'h400, 1);
    cpu(1, 3, 32'h400, 0);
    cpu(3, 3, 32'h400, 0);
    wait_idle();
    cpu(3, 2, 32'h300, 0);
    cpu(0, 2, 32'h300, 0);
    cpu(3, 1, 32'h777, 0);

    phase = "R5";
    cfg_nocache = 1;
    cpu(0, 0, 32'h100, 0);
    cpu(2, 1, 32'h500, 1);
    cpu(1, 0, 32'h100, 1);
    cfg_nocache = 0; cfg_nowrite = 1;
    cpu(0, 0, 32'h100, 0);
    cpu(2, 1, 32'h500, 1);
    cfg_nowrite = 0;
    cpu(0, 1, 32'h500, 0);
    cpu(0, 0, 32'h100, 0);

    phase = "R11";
    snp_stb = 1; snp_addr = 32'h100; snp_inv = 0;
    cpu_req = 1; cpu_op = 2; cpu_set = 0; cpu_addr = 32'hAAA; pol_wb = 1;
    @(negedge clk);
    snp_stb = 0; cpu_req = 0;
    cyc(2);
    cpu(0, 0, 32'hAAA, 0);

    phase = "R10";
    cpu(2, 0, 32'hA00, 1); cpu(1, 0, 32'hA00, 0);
    cpu(2, 1, 32'hB00, 0);
    cpu(2, 2, 32'hC00, 1);
    cpu(2, 3, 32'hD00, 1); cpu(1, 3, 32'hD00, 0);
    flush_req = 1;
    cpu_req = 1; cpu_op = 2; cpu_set = 1; cpu_addr = 32'hEEE; pol_wb = 1;
    @(negedge clk);
    flush_req = 0;
    phase = "R11";
    cyc(3);
    cpu_op = 1; cpu_set = 0; cpu_addr = 32'hA00;
    snp_stb = 1; snp_addr = 32'hD00;
    cyc(2);
    cpu_req = 0; snp_stb = 0;
    phase = "R10";
    wait_idle();
    snoop(32'hA00, 0);
    snoop(32'hB00, 0);
    snoop(32'hC00, 0);
    snoop(32'hD00, 0);
    cpu(0, 1, 32'hEEE, 0);
    flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    wait_idle();
    cyc(2);

    over = 1;
    summary();
    $finish;
  end
endmodule